// File: doc/BRIEF.md
# Single-Core Miss Request Sequencer

This block sits between a core's miss queues and an external memory port. Eight request sources each present a valid flag, a thread id and an address. The sources are load miss, store miss, instruction miss, flush, replacement, data-invalidate, I/O write and I/O read. The sequencer picks one pending request with a fixed priority and serves only that one until it is finished. Each source has its own dequeue pulse, which the sequencer raises when that source's request has been consumed.

Every request belongs to one of two classes. The read class covers load, store, instruction and I/O read; these issue a memory read and wait for its data. The write class covers flush, replacement, invalidate and I/O write; these issue a memory write and finish at once. A request that the core marks as not executable is dropped or retried without touching memory. The outcome depends on the source.

When a load or store read completes, the block emits a cache update command. The victim way comes from a round-robin counter kept for each set. The command is a replacement once every way of that set has been filled, and an info-and-data update before that. When an instruction read completes, the block returns the data and thread id to the thread-control side.

Top module: `miss_sequencer`

## Requirements
- R1: During reset and in the first cycle after it, every dequeue bit, `mem_req_valid`, `upd_valid` and `ins_valid` is low.
- R2: Request bit positions are 0 replacement, 1 flush, 2 invalidate, 3 store, 4 load, 5 instruction, 6 I/O write and 7 I/O read. The lowest set bit has the highest priority, and the memory request carries the address of the winning source.
- R3: At most one dequeue bit is high in any cycle. A new request is granted only after the request in service has been dequeued.
- R4: A write-class request (bits 0, 1, 2 and 6) drives `mem_req_write`=1, and its dequeue pulse is high in the same cycle as `mem_req_valid`.
- R5: A read-class request (bits 3, 4, 5 and 7) drives `mem_req_write`=0. It is dequeued in the cycle after `mem_rsp_valid` is sampled high, and not before.
- R6: `mem_req_valid` is high only in a cycle whose preceding cycle had `mem_ready` high. While `mem_ready` is low, the request waits.
- R7: With `req_exec` low, no memory request is issued. A load, store, flush or invalidate is dequeued two cycles after it is presented to an idle block. A replacement, instruction or I/O request is never dequeued and is retried.
- R8: When a load or store completes, `upd_valid` pulses together with its dequeue. The pulse carries the request's address, its thread id, privilege value 2'b11 and the response data.
- R9: The way is the number of earlier fills to that set modulo WAYS, where the set is address bits [OFFS_W +: log2(SETS)]. `upd_cmd` is 1 (replacement) when at least WAYS fills to that set came before, and 0 (update info and data) otherwise.
- R10: When an instruction read completes, `ins_valid` pulses with the request's thread id and the response data. An I/O read completes with its dequeue only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 8 | Pending flag per source (bit order in R2) |
| req_tid | input | 8*TID_W | Thread id per source, source i at [i*TID_W +: TID_W] |
| req_addr | input | 8*ADDR_W | Address per source, source i at [i*ADDR_W +: ADDR_W] |
| req_deq | output | 8 | One-cycle dequeue pulse per source |
| req_exec | input | 1 | Request in service may be executed |
| mem_ready | input | 1 | Memory can take a request on the next cycle |
| mem_req_valid | output | 1 | Memory request pulse |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | ADDR_W | Memory request address |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_data | input | DATA_W | Read response data |
| upd_valid | output | 1 | Cache update command pulse |
| upd_way | output | log2(WAYS) | Victim way |
| upd_addr | output | ADDR_W | Update address |
| upd_tid | output | TID_W | Requesting thread |
| upd_priv | output | 2 | Granted privileges (read, write) |
| upd_cmd | output | 1 | 1 replacement, 0 update info and data |
| upd_data | output | DATA_W | Line data from memory |
| ins_valid | output | 1 | Instruction data return pulse |
| ins_tid | output | TID_W | Thread of the instruction miss |
| ins_data | output | DATA_W | Instruction data |

## Verification
All outputs are registered. A memory request therefore appears two cycles after a request reaches the idle block, or later if `mem_ready` stalls it. A write's dequeue appears in that same cycle. For a read, the dequeue and the update or instruction return appear one cycle after the response is sampled. The bench drives inputs and samples outputs on the falling edge. Every cycle it compares the dequeue, update and instruction-return outputs against the values its memory and queue model expects for that cycle, so an early, late or extra pulse is caught. The sweep covers all 256 combinations of pending sources, with rotating response latency and periodic `mem_ready` stalls. A separate pass holds `req_exec` low and checks each source's dequeue at exactly the second cycle.

// File: rtl/msq_pkg.sv
`timescale 1ns/1ps
// Shared constants for the miss sequencer: source numbering, which sources
// form the write class, which are dropped when not executable, FSM states.
package msq_pkg;
    localparam int NSRC      = 8;
    localparam int SRC_REPL  = 0;
    localparam int SRC_FLUSH = 1;
    localparam int SRC_INV   = 2;
    localparam int SRC_STORE = 3;
    localparam int SRC_LOAD  = 4;
    localparam int SRC_INSTR = 5;
    localparam int SRC_IOWR  = 6;
    localparam int SRC_IORD  = 7;

    // Write-class sources: replacement, flush, invalidate, I/O write.
    localparam logic [NSRC-1:0] WRITE_MASK  = 8'b0100_0111;
    // Sources consumed when found not executable: flush, invalidate, store, load.
    localparam logic [NSRC-1:0] NOEXEC_MASK = 8'b0001_1110;

    localparam logic CMD_UPDATE  = 1'b0;
    localparam logic CMD_REPLACE = 1'b1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/msq_prio_arbiter.sv
`timescale 1ns/1ps
// Fixed-priority arbiter: bit 0 wins over every other bit.
// Assumes nothing about the request vector; grant is one-hot or zero.
module msq_prio_arbiter #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    logic [N-1:0] lower_busy;

    // Build the chain that marks a higher-priority request below each bit.
    assign lower_busy[0] = 1'b0;
    for (genvar i = 1; i < N; i++) begin : g_chain
        assign lower_busy[i] = lower_busy[i-1] | req[i-1];
    end

    // Grant the first request not masked by a lower index.
    assign gnt = req & ~lower_busy;
    assign any = |req;
endmodule

// File: rtl/msq_grant_mux.sv
`timescale 1ns/1ps
// Selects the thread id and address of the one-hot granted source.
// Assumes gnt is one-hot or zero; zero yields zero fields.
module msq_grant_mux #(
    parameter int N      = 8,
    parameter int TID_W  = 2,
    parameter int ADDR_W = 16
) (
    input  logic [N-1:0]        gnt,
    input  logic [N*TID_W-1:0]  tids,
    input  logic [N*ADDR_W-1:0] addrs,
    output logic [TID_W-1:0]    sel_tid,
    output logic [ADDR_W-1:0]   sel_addr
);
    // AND-OR selection across all sources.
    always_comb begin
        sel_tid  = '0;
        sel_addr = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) begin
                sel_tid  = sel_tid  | tids[i*TID_W +: TID_W];
                sel_addr = sel_addr | addrs[i*ADDR_W +: ADDR_W];
            end
        end
    end
endmodule

// File: rtl/msq_way_tracker.sv
`timescale 1ns/1ps
// Per-set round-robin victim pointer plus a sticky "set full" flag.
// Assumes WAYS is a power of two of at least 2; one fill per advance pulse.
module msq_way_tracker #(
    parameter int SETS = 8,
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             advance,
    output logic [WAY_W-1:0] way,
    output logic             full
);
    logic [WAY_W-1:0] ptr_q  [SETS];
    logic [SETS-1:0]  full_q;
    logic             at_last;

    // Look up the indexed set.
    assign way     = ptr_q[idx];
    assign full    = full_q[idx];
    assign at_last = (ptr_q[idx] == WAY_W'(WAYS - 1));

    // Step the pointer of the filled set and mark the set full on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
            full_q <= '0;
        end else if (advance) begin
            ptr_q[idx] <= at_last ? '0 : ptr_q[idx] + 1'b1;
            if (at_last) full_q[idx] <= 1'b1;
        end
    end
endmodule

// File: rtl/miss_sequencer.sv
`timescale 1ns/1ps
// Miss request sequencer: grants one of eight request sources by fixed
// priority, issues it to memory and completes it. Assumes a source's valid
// drops by the clock edge that samples its dequeue pulse, and that a memory
// response comes at least one cycle after the request pulse.
module miss_sequencer
    import msq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int TID_W  = 2,
    parameter int DATA_W = 32,
    parameter int SETS   = 8,
    parameter int WAYS   = 4,
    parameter int OFFS_W = 2,
    localparam int WAY_W = $clog2(WAYS),
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSRC-1:0]         req_valid,
    input  logic [NSRC*TID_W-1:0]   req_tid,
    input  logic [NSRC*ADDR_W-1:0]  req_addr,
    output logic [NSRC-1:0]         req_deq,
    input  logic                    req_exec,
    input  logic                    mem_ready,
    output logic                    mem_req_valid,
    output logic                    mem_req_write,
    output logic [ADDR_W-1:0]       mem_req_addr,
    input  logic                    mem_rsp_valid,
    input  logic [DATA_W-1:0]       mem_rsp_data,
    output logic                    upd_valid,
    output logic [WAY_W-1:0]        upd_way,
    output logic [ADDR_W-1:0]       upd_addr,
    output logic [TID_W-1:0]        upd_tid,
    output logic [1:0]              upd_priv,
    output logic                    upd_cmd,
    output logic [DATA_W-1:0]       upd_data,
    output logic                    ins_valid,
    output logic [TID_W-1:0]        ins_tid,
    output logic [DATA_W-1:0]       ins_data
);
    seq_state_e        state_q;
    logic [NSRC-1:0]   gnt, gnt_q;
    logic              any_req;
    logic [TID_W-1:0]  sel_tid, tid_q;
    logic [ADDR_W-1:0] sel_addr, addr_q;
    logic              wr_q;
    logic [WAY_W-1:0]  vic_way;
    logic              set_full;
    logic              fill_now;
    logic              ldst_q;

    msq_prio_arbiter #(.N(NSRC)) u_arb (
        .req (req_valid),
        .gnt (gnt),
        .any (any_req)
    );

    msq_grant_mux #(.N(NSRC), .TID_W(TID_W), .ADDR_W(ADDR_W)) u_mux (
        .gnt      (gnt),
        .tids     (req_tid),
        .addrs    (req_addr),
        .sel_tid  (sel_tid),
        .sel_addr (sel_addr)
    );

    // A load or store read completes this cycle.
    assign ldst_q   = gnt_q[SRC_LOAD] | gnt_q[SRC_STORE];
    assign fill_now = (state_q == ST_WAIT) && mem_rsp_valid && ldst_q;

    msq_way_tracker #(.SETS(SETS), .WAYS(WAYS)) u_ways (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (addr_q[OFFS_W +: IDX_W]),
        .advance (fill_now),
        .way     (vic_way),
        .full    (set_full)
    );

    // Sequencer FSM with registered pulses and held data fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            gnt_q         <= '0;
            tid_q         <= '0;
            addr_q        <= '0;
            wr_q          <= 1'b0;
            req_deq       <= '0;
            mem_req_valid <= 1'b0;
            mem_req_write <= 1'b0;
            mem_req_addr  <= '0;
            upd_valid     <= 1'b0;
            upd_way       <= '0;
            upd_addr      <= '0;
            upd_tid       <= '0;
            upd_priv      <= '0;
            upd_cmd       <= CMD_UPDATE;
            upd_data      <= '0;
            ins_valid     <= 1'b0;
            ins_tid       <= '0;
            ins_data      <= '0;
        end else begin
            req_deq       <= '0;
            mem_req_valid <= 1'b0;
            upd_valid     <= 1'b0;
            ins_valid     <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    // Hold off while a dequeue is still being taken by the queues.
                    if (any_req && (req_deq == '0)) begin
                        gnt_q   <= gnt;
                        tid_q   <= sel_tid;
                        addr_q  <= sel_addr;
                        wr_q    <= |(gnt & WRITE_MASK);
                        state_q <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (!req_exec) begin
                        req_deq <= gnt_q & NOEXEC_MASK;
                        state_q <= ST_IDLE;
                    end else if (mem_ready) begin
                        mem_req_valid <= 1'b1;
                        mem_req_write <= wr_q;
                        mem_req_addr  <= addr_q;
                        if (wr_q) begin
                            req_deq <= gnt_q;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        req_deq <= gnt_q;
                        state_q <= ST_IDLE;
                        if (gnt_q[SRC_INSTR]) begin
                            ins_valid <= 1'b1;
                            ins_tid   <= tid_q;
                            ins_data  <= mem_rsp_data;
                        end
                        if (ldst_q) begin
                            upd_valid <= 1'b1;
                            upd_way   <= vic_way;
                            upd_addr  <= addr_q;
                            upd_tid   <= tid_q;
                            upd_priv  <= 2'b11;
                            upd_cmd   <= set_full ? CMD_REPLACE : CMD_UPDATE;
                            upd_data  <= mem_rsp_data;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/miss_sequencer_chk.sv
`timescale 1ns/1ps
// Port-level protocol checker for miss_sequencer, bound to every instance.
module miss_sequencer_chk
    import msq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] req_deq,
    input logic            mem_ready,
    input logic            mem_req_valid,
    input logic            mem_req_write,
    input logic            upd_valid,
    input logic [1:0]      upd_priv,
    input logic            ins_valid
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (req_deq == '0 && !mem_req_valid && !upd_valid && !ins_valid));

    // R3
    one_deq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_deq));

    // R4
    write_deq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> ($countones(req_deq & WRITE_MASK) == 1));

    // R5
    read_no_deq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write) |-> (req_deq == '0));

    // R6
    ready_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> $past(mem_ready));

    // R8
    upd_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (upd_priv == 2'b11 && (req_deq[SRC_LOAD] || req_deq[SRC_STORE])));

    // R10
    ins_deq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> (req_deq[SRC_INSTR] && !upd_valid));
endmodule

bind miss_sequencer miss_sequencer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_deq       (req_deq),
    .mem_ready     (mem_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .upd_valid     (upd_valid),
    .upd_priv      (upd_priv),
    .ins_valid     (ins_valid)
);

// File: tb/tb_miss_sequencer.sv
`timescale 1ns/1ps
// Sweeps all pending-source combinations against a latency-varying memory
// model and a non-executable pass; expected values are computed here.
module tb_miss_sequencer;
    localparam int AW = 16;
    localparam int TW = 2;
    localparam int DW = 32;
    localparam logic [7:0] WMASK  = 8'b0100_0111;
    localparam logic [7:0] NXMASK = 8'b0001_1110;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [7:0]    req_valid;
    logic [8*TW-1:0] req_tid;
    logic [8*AW-1:0] req_addr;
    logic [7:0]    req_deq;
    logic          req_exec, mem_ready;
    logic          mem_req_valid, mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid;
    logic [DW-1:0] mem_rsp_data;
    logic          upd_valid;
    logic [1:0]    upd_way;
    logic [AW-1:0] upd_addr;
    logic [TW-1:0] upd_tid;
    logic [1:0]    upd_priv;
    logic          upd_cmd;
    logic [DW-1:0] upd_data;
    logic          ins_valid;
    logic [TW-1:0] ins_tid;
    logic [DW-1:0] ins_data;

    miss_sequencer dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tid(req_tid),
        .req_addr(req_addr), .req_deq(req_deq), .req_exec(req_exec),
        .mem_ready(mem_ready), .mem_req_valid(mem_req_valid),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .upd_valid(upd_valid), .upd_way(upd_way), .upd_addr(upd_addr),
        .upd_tid(upd_tid), .upd_priv(upd_priv), .upd_cmd(upd_cmd),
        .upd_data(upd_data), .ins_valid(ins_valid), .ins_tid(ins_tid),
        .ins_data(ins_data)
    );

    always #2 clk = ~clk;

    int vecs = 0, fails = 0;
    int cur_pat = 0, cur = 0, rsp_cnt = 0, nreq = 0, cyc = 0;
    bit rsp_sent = 0, ready_prev = 1, stall_en = 0;
    logic [7:0] pend = '0;
    int fills [8];

    function automatic logic [AW-1:0] addr_of(int s);
        return AW'(cur_pat * 37 + s * 13 + 5);
    endfunction
    function automatic logic [TW-1:0] tid_of(int s);
        return TW'((cur_pat + s) % 4);
    endfunction
    function automatic logic [DW-1:0] data_of(logic [AW-1:0] a);
        return {16'hC3C3, a};
    endfunction
    function automatic int first_of(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        vecs++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    endtask

    task automatic drive_fields();
        for (int s = 0; s < 8; s++) begin
            req_tid[s*TW +: TW]  = tid_of(s);
            req_addr[s*AW +: AW] = addr_of(s);
        end
    endtask

    // One falling-edge observation with the memory and queue model.
    task automatic obs();
        logic [7:0]    ed;
        logic [AW-1:0] ea;
        bit eu, ei;
        int st, src;
        ed = '0; eu = 0; ei = 0;
        if (rsp_sent) begin
            ed = 8'(1 << cur);
            rsp_sent = 0;
            mem_rsp_valid = 1'b0;
            ea = addr_of(cur);
            if (cur == 3 || cur == 4) begin
                eu = 1;
                st = (int'(ea) >> 2) % 8;
                chk("R8 update address", upd_addr, ea);
                chk("R8 update thread", upd_tid, tid_of(cur));
                chk("R8 privileges", upd_priv, 2'b11);
                chk("R8 update data", upd_data, data_of(ea));
                chk("R9 victim way", upd_way, fills[st] % 4);
                chk("R9 command", upd_cmd, fills[st] >= 4);
                fills[st]++;
            end
            if (cur == 5) begin
                ei = 1;
                chk("R10 instruction thread", ins_tid, tid_of(cur));
                chk("R10 instruction data", ins_data, data_of(ea));
            end
        end
        if (mem_req_valid) begin
            chk("R6 ready before request", ready_prev, 1);
            src = first_of(pend);
            chk("R2 winning source address", mem_req_addr, addr_of(src));
            chk(WMASK[src] ? "R4 write kind" : "R5 read kind", mem_req_write, WMASK[src]);
            cur = src;
            if (WMASK[src]) ed = 8'(1 << src);
            else rsp_cnt = 1 + nreq % 3;
            nreq++;
        end
        chk("R3 dequeue pulse", req_deq, ed);
        chk("R8 update pulse", upd_valid, eu);
        chk("R10 instruction pulse", ins_valid, ei);
        pend = pend & ~req_deq;
        req_valid = pend;
        if (rsp_cnt > 0) begin
            rsp_cnt--;
            if (rsp_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = data_of(addr_of(cur));
                rsp_sent = 1;
            end
        end
        cyc++;
        mem_ready  = stall_en ? ((cyc % 5) != 0) : 1'b1;
        ready_prev = mem_ready;
    endtask

    task automatic drain();
        int guard = 0;
        while ((pend != 0 || rsp_cnt > 0 || rsp_sent) && guard < 400) begin
            @(negedge clk);
            obs();
            guard++;
        end
        if (guard >= 400) chk("R3 request never finished", 1, 0);
        repeat (2) begin
            @(negedge clk);
            obs();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) fills[i] = 0;
        rst_n = 1'b0; req_valid = '0; req_exec = 1'b1; mem_ready = 1'b1;
        mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        drive_fields();
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {req_deq, mem_req_valid, upd_valid, ins_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 first cycle after reset", {req_deq, mem_req_valid, upd_valid, ins_valid}, 0);

        // R2..R6, R8..R10: every combination of pending sources.
        stall_en = 1;
        for (int p = 0; p < 256; p++) begin
            cur_pat = p;
            drive_fields();
            pend = 8'(p);
            req_valid = pend;
            drain();
        end
        stall_en = 0;

        // R7: each source alone with the request not executable.
        for (int s = 0; s < 8; s++) begin
            cur_pat = 300 + s;
            drive_fields();
            req_exec = 1'b0;
            pend = 8'(1 << s);
            req_valid = pend;
            for (int k = 1; k <= 8; k++) begin
                @(negedge clk);
                chk("R7 no memory request", mem_req_valid, 0);
                chk("R7 dequeue when not executable", req_deq,
                    (k == 2 && NXMASK[s]) ? 8'(1 << s) : 8'h00);
                pend = pend & ~req_deq;
                req_valid = pend;
            end
            req_exec = 1'b1;
            drain();
        end

        summary();
        $finish;
    end
endmodule